// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block is the issue-stage control of a statically scheduled two-way pipeline. Fetch hands it one aligned packet per cycle through a valid/ready handshake. Each packet holds two 32-bit words. The lower word feeds the ALU/branch pipe and the upper word feeds the load/store pipe. The block decodes each word far enough to learn its class, its destination and its source registers. It then does one of four things with the packet: issue both slots, split the packet, stall it for one cycle, or drop it as illegal.

A split happens when the load/store slot reads the register that the ALU/branch slot of the same packet writes. In that case the ALU/branch word issues at once and the load/store word is captured. The captured word issues alone on the next cycle, with a bubble in the ALU/branch pipe. A stall happens when either slot reads the destination of a load that issued in the cycle just before. That cycle issues nothing, and the packet goes ahead on the following cycle. All other dependencies between packets are left to forwarding and cost no cycle.

Control is a two-state machine. In `S_FLOW`, packets are judged as they arrive. `S_FLOW` moves to `S_HELD` when a packet is split. `S_HELD` issues the captured word, keeps fetch stalled, and always returns to `S_FLOW` on the next edge. A synchronous reset returns the machine to `S_FLOW`, discards any captured word and forgets the tracked load.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) leaves the block in `S_FLOW` with no captured word and no tracked load. After reset, an idle cycle issues nothing, and a packet reading the destination of a load issued before reset issues without a stall.
- R2: Decoding uses opcode bits [31:26]. Rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. Opcodes 0x00 (R-type: writes rd, reads rs and rt), 0x08 (add-immediate: writes rt, reads rs), 0x04 and 0x05 (branches: read rs and rt) are ALU/branch class. Opcode 0x23 is a load (writes rt, reads rs) and 0x2B is a store (reads rs and rt). The all-zero word is a nop. The packet's bits [31:0] are slot 0 and bits [63:32] are slot 1.
- R3: When a legal packet has no hazard, the block accepts it (`pkt_ready` high). Every non-nop slot issues in the same cycle, and a nop slot leaves its pipe's valid low.
- R4: A packet is illegal when slot 0 holds a load/store or an unknown opcode, or when slot 1 holds an ALU/branch word or an unknown opcode. An illegal packet raises `illegal_pkt`, issues neither slot, and is accepted and dropped.
- R5: A packet splits when the slot 0 destination equals the slot 1 base register, or the slot 1 store data register. In that cycle only the ALU/branch slot issues and the packet is accepted. In the next cycle only the captured slot 1 word issues, and `pkt_ready` is low.
- R6: A load that issues with rt ≠ 0 is tracked for one cycle. In the next cycle, a packet with any source in either slot equal to that rt issues nothing and is not accepted. In the cycle after that, the packet proceeds.
- R7: Register 0 is never a hazard source or destination. It causes neither a split nor a stall.
- R8: A non-load result that a following packet reads causes no stall.
- R9: A load issued from a captured split slot is tracked like any other load.
- R10: With `pkt_valid` low in `S_FLOW`, nothing issues and `pkt_ready` is high. Such a cycle also ends the tracking of any load.
- R11: An issued word equals the slot word it came from. An issue-word output is zero whenever its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Fetch presents a packet |
| pkt_data | input | 64 | Packet: slot 0 in [31:0], slot 1 in [63:32] |
| pkt_ready | output | 1 | Packet accepted this cycle; low holds fetch |
| alu_issue_valid | output | 1 | ALU/branch pipe receives an instruction |
| alu_issue_word | output | 32 | Word sent to the ALU/branch pipe |
| mem_issue_valid | output | 1 | Load/store pipe receives an instruction |
| mem_issue_word | output | 32 | Word sent to the load/store pipe |
| illegal_pkt | output | 1 | Current packet violates the slot-class rule |

## Verification
The bench builds the block with the package defaults: 32-bit words, 5-bit register specifiers and a 6-bit opcode. Random words draw their registers from r0 to r3 only. That narrow range makes same-packet collisions, load-use collisions and register 0 cases happen often. The random mix also places wrong-class words, unknown opcodes, nop slots and idle cycles often enough to reach every branch of both states. This includes a split whose captured word is a load that the next packet reads.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned PKT_W  = 2 * WORD_W;
    localparam int unsigned SLOTS  = 2;

    localparam int unsigned OPC_LSB = WORD_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RT_LSB  = RS_LSB - REG_W;
    localparam int unsigned RD_LSB  = RT_LSB - REG_W;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
    localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_ALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BAD
    } slot_cls_e;

    typedef struct packed {
        slot_cls_e        cls;
        logic             dst_v;
        logic [REG_W-1:0] dst;
        logic             src_a_v;
        logic [REG_W-1:0] src_a;
        logic             src_b_v;
        logic [REG_W-1:0] src_b;
    } slot_dec_t;

    typedef enum logic {
        S_FLOW,
        S_HELD
    } issue_state_e;

endpackage

// File: rtl/dis_slot_decode.sv
module dis_slot_decode
    import dis_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output slot_dec_t         dec
);

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rd;
    logic             wr_en;
    logic             rd_a_en;
    logic             rd_b_en;

    assign opc = word[OPC_LSB +: OPC_W];
    assign rs  = word[RS_LSB +: REG_W];
    assign rt  = word[RT_LSB +: REG_W];
    assign rd  = word[RD_LSB +: REG_W];

    always_comb begin
        dec     = '0;
        wr_en   = 1'b0;
        rd_a_en = 1'b0;
        rd_b_en = 1'b0;
        dec.src_a = rs;
        dec.src_b = rt;
        dec.dst   = rt;
        if (word == '0) begin
            dec.cls = CLS_NOP;
        end else begin
            unique case (opc)
                OPC_SPECIAL: begin
                    dec.cls = CLS_ALU;
                    dec.dst = rd;
                    wr_en   = 1'b1;
                    rd_a_en = 1'b1;
                    rd_b_en = 1'b1;
                end
                OPC_ADDI: begin
                    dec.cls = CLS_ALU;
                    wr_en   = 1'b1;
                    rd_a_en = 1'b1;
                end
                OPC_BEQ, OPC_BNE: begin
                    dec.cls = CLS_ALU;
                    rd_a_en = 1'b1;
                    rd_b_en = 1'b1;
                end
                OPC_LOAD: begin
                    dec.cls = CLS_LOAD;
                    wr_en   = 1'b1;
                    rd_a_en = 1'b1;
                end
                OPC_STORE: begin
                    dec.cls = CLS_STORE;
                    rd_a_en = 1'b1;
                    rd_b_en = 1'b1;
                end
                default: begin
                    dec.cls = CLS_BAD;
                end
            endcase
        end
        dec.dst_v   = wr_en   && (dec.dst   != '0);
        dec.src_a_v = rd_a_en && (dec.src_a != '0);
        dec.src_b_v = rd_b_en && (dec.src_b != '0);
    end

endmodule

// File: rtl/dis_hazard.sv
module dis_hazard
    import dis_pkg::*;
(
    input  slot_dec_t        dec_alu,
    input  slot_dec_t        dec_mem,
    input  logic             ld_v,
    input  logic [REG_W-1:0] ld_reg,
    output logic             bad_order,
    output logic             intra_hz,
    output logic             load_use_hz
);

    function automatic logic reads_reg(input slot_dec_t d, input logic [REG_W-1:0] r);
        return (d.src_a_v && (d.src_a == r)) || (d.src_b_v && (d.src_b == r));
    endfunction

    logic unused_mem_dst;
    assign unused_mem_dst = ^{dec_mem.dst_v, dec_mem.dst};

    always_comb begin
        bad_order = 1'b0;
        unique case (dec_alu.cls)
            CLS_LOAD, CLS_STORE, CLS_BAD: bad_order = 1'b1;
            default:                      bad_order = bad_order;
        endcase
        unique case (dec_mem.cls)
            CLS_ALU, CLS_BAD: bad_order = 1'b1;
            default:          bad_order = bad_order;
        endcase
    end

    assign intra_hz    = dec_alu.dst_v && reads_reg(dec_mem, dec_alu.dst);
    assign load_use_hz = ld_v && (reads_reg(dec_alu, ld_reg) || reads_reg(dec_mem, ld_reg));

endmodule

// File: rtl/dis_load_track.sv
module dis_load_track
    import dis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_v,
    input  logic [WORD_W-1:0] issue_word,
    output logic              ld_v,
    output logic [REG_W-1:0]  ld_reg
);

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rt;
    logic             unused_trk;

    assign opc        = issue_word[OPC_LSB +: OPC_W];
    assign rt         = issue_word[RT_LSB +: REG_W];
    assign unused_trk = ^{issue_word[RS_LSB +: REG_W], issue_word[RT_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_v   <= 1'b0;
            ld_reg <= '0;
        end else begin
            ld_v   <= issue_v && (opc == OPC_LOAD) && (rt != '0);
            ld_reg <= rt;
        end
    end

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
    import dis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_ready,
    output logic              alu_issue_valid,
    output logic [WORD_W-1:0] alu_issue_word,
    output logic              mem_issue_valid,
    output logic [WORD_W-1:0] mem_issue_word,
    output logic              illegal_pkt
);

    slot_dec_t         dec [SLOTS];
    issue_state_e      state_q;
    issue_state_e      state_d;
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] held_d;
    logic              ld_v;
    logic [REG_W-1:0]  ld_reg;
    logic              bad_order;
    logic              intra_hz;
    logic              load_use_hz;
    logic              mem_is_ls;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        dis_slot_decode u_dec (
            .word (pkt_data[s*WORD_W +: WORD_W]),
            .dec  (dec[s])
        );
    end

    dis_hazard u_hazard (
        .dec_alu     (dec[0]),
        .dec_mem     (dec[1]),
        .ld_v        (ld_v),
        .ld_reg      (ld_reg),
        .bad_order   (bad_order),
        .intra_hz    (intra_hz),
        .load_use_hz (load_use_hz)
    );

    dis_load_track u_track (
        .clk        (clk),
        .rst        (rst),
        .issue_v    (mem_issue_valid),
        .issue_word (mem_issue_word),
        .ld_v       (ld_v),
        .ld_reg     (ld_reg)
    );

    assign mem_is_ls = (dec[1].cls == CLS_LOAD) || (dec[1].cls == CLS_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FLOW;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d         = state_q;
        held_d          = held_q;
        pkt_ready       = 1'b0;
        alu_issue_valid = 1'b0;
        alu_issue_word  = '0;
        mem_issue_valid = 1'b0;
        mem_issue_word  = '0;
        illegal_pkt     = 1'b0;
        unique case (state_q)
            S_FLOW: begin
                pkt_ready = 1'b1;
                if (pkt_valid) begin
                    if (bad_order) begin
                        illegal_pkt = 1'b1;
                    end else if (load_use_hz) begin
                        pkt_ready = 1'b0;
                    end else if (intra_hz) begin
                        alu_issue_valid = 1'b1;
                        alu_issue_word  = pkt_data[0 +: WORD_W];
                        held_d          = pkt_data[WORD_W +: WORD_W];
                        state_d         = S_HELD;
                    end else begin
                        alu_issue_valid = (dec[0].cls == CLS_ALU);
                        alu_issue_word  = alu_issue_valid ? pkt_data[0 +: WORD_W] : '0;
                        mem_issue_valid = mem_is_ls;
                        mem_issue_word  = mem_is_ls ? pkt_data[WORD_W +: WORD_W] : '0;
                    end
                end
            end
            S_HELD: begin
                mem_issue_valid = 1'b1;
                mem_issue_word  = held_q;
                held_d          = '0;
                state_d         = S_FLOW;
            end
        endcase
    end

endmodule

// File: rtl/dis_issue_chk.sv
module dis_issue_chk
    import dis_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pkt_valid,
    input logic [PKT_W-1:0]  pkt_data,
    input logic              pkt_ready,
    input logic              alu_issue_valid,
    input logic [WORD_W-1:0] alu_issue_word,
    input logic              mem_issue_valid,
    input logic [WORD_W-1:0] mem_issue_word,
    input logic              illegal_pkt
);

    // R4
    illegal_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_pkt |-> (!alu_issue_valid && !mem_issue_valid));

    // R5
    split_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && alu_issue_valid && !mem_issue_valid && !illegal_pkt
         && (pkt_data[WORD_W +: WORD_W] != '0))
        |=> (mem_issue_valid && !alu_issue_valid && !pkt_ready
             && (mem_issue_word == $past(pkt_data[WORD_W +: WORD_W]))));

    // R6
    stall_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready && !mem_issue_valid) |-> !alu_issue_valid);

    // R6
    stall_once_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready && !mem_issue_valid) |=> (!pkt_valid || pkt_ready));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && pkt_ready) |-> (!alu_issue_valid && !mem_issue_valid));

    // R3
    nop_never_alu_chk: assert property (@(posedge clk) disable iff (rst)
        alu_issue_valid |-> (alu_issue_word != '0));

    // R3
    nop_never_mem_chk: assert property (@(posedge clk) disable iff (rst)
        mem_issue_valid |-> (mem_issue_word != '0));

endmodule

bind dual_issue_ctrl dis_issue_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .pkt_valid       (pkt_valid),
    .pkt_data        (pkt_data),
    .pkt_ready       (pkt_ready),
    .alu_issue_valid (alu_issue_valid),
    .alu_issue_word  (alu_issue_word),
    .mem_issue_valid (mem_issue_valid),
    .mem_issue_word  (mem_issue_word),
    .illegal_pkt     (illegal_pkt)
);

// File: tb/dual_issue_ctrl_bench.sv
module dual_issue_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        pkt_ready;
    logic        alu_issue_valid;
    logic [31:0] alu_issue_word;
    logic        mem_issue_valid;
    logic [31:0] mem_issue_word;
    logic        illegal_pkt;

    int checks = 0;
    int failures = 0;

    bit          m_split = 0;
    logic [31:0] m_held = '0;
    bit          m_ldv = 0;
    logic [4:0]  m_ldr = '0;

    logic        e_ready, e_av, e_mv, e_ill;
    logic [31:0] e_aw, e_mw;
    string       e_tag;

    always #5 clk = ~clk;

    dual_issue_ctrl u_dual_issue_ctrl (
        .clk             (clk),
        .rst             (rst),
        .pkt_valid       (pkt_valid),
        .pkt_data        (pkt_data),
        .pkt_ready       (pkt_ready),
        .alu_issue_valid (alu_issue_valid),
        .alu_issue_word  (alu_issue_word),
        .mem_issue_valid (mem_issue_valid),
        .mem_issue_word  (mem_issue_word),
        .illegal_pkt     (illegal_pkt)
    );

    function automatic logic [31:0] w_r(input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    endfunction
    function automatic logic [31:0] w_addi(input int rt, input int rs);
        return {6'h08, 5'(rs), 5'(rt), 16'h0007};
    endfunction
    function automatic logic [31:0] w_br(input int rs, input int rt);
        return {6'h05, 5'(rs), 5'(rt), 16'hFFFC};
    endfunction
    function automatic logic [31:0] w_lw(input int rt, input int rs);
        return {6'h23, 5'(rs), 5'(rt), 16'h0010};
    endfunction
    function automatic logic [31:0] w_sw(input int rt, input int rs);
        return {6'h2B, 5'(rs), 5'(rt), 16'h0008};
    endfunction

    // class codes: 0 nop, 1 alu/branch, 2 load, 3 store, 4 unknown
    function automatic int m_cls(input logic [31:0] w);
        if (w == 0) return 0;
        case (w[31:26])
            6'h00, 6'h08, 6'h04, 6'h05: return 1;
            6'h23: return 2;
            6'h2B: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic bit m_reads(input logic [31:0] w, input logic [4:0] r);
        int c = m_cls(w);
        if (r == 0) return 0;
        if (c == 1 && w[31:26] == 6'h08) return w[25:21] == r;
        if (c == 1 || c == 3) return (w[25:21] == r) || (w[20:16] == r);
        if (c == 2) return w[25:21] == r;
        return 0;
    endfunction

    function automatic logic [5:0] m_dst(input logic [31:0] w);
        int c = m_cls(w);
        logic [4:0] r;
        if (c == 1 && w[31:26] == 6'h00) r = w[15:11];
        else if ((c == 1 && w[31:26] == 6'h08) || c == 2) r = w[20:16];
        else return 6'd0;
        return {r != 0, r};
    endfunction

    task automatic model_eval(input logic v, input logic [63:0] d);
        logic [31:0] w0 = d[31:0];
        logic [31:0] w1 = d[63:32];
        int c0 = m_cls(w0);
        int c1 = m_cls(w1);
        logic [5:0] d0;
        e_ready = 0; e_av = 0; e_aw = 0; e_mv = 0; e_mw = 0; e_ill = 0;
        if (m_split) begin
            e_mv = 1; e_mw = m_held;
            e_tag = (m_cls(m_held) == 2) ? "R9" : "R5";
            m_split = 0;
            m_ldv = (m_cls(m_held) == 2) && (m_held[20:16] != 0);
            m_ldr = m_held[20:16];
        end else begin
            e_ready = 1;
            if (!v) begin
                e_tag = "R10"; m_ldv = 0;
            end else if (c0 >= 2 || c1 == 1 || c1 == 4) begin
                e_ill = 1; e_tag = "R4"; m_ldv = 0;
            end else if (m_ldv && (m_reads(w0, m_ldr) || m_reads(w1, m_ldr))) begin
                e_ready = 0; e_tag = "R6"; m_ldv = 0;
            end else begin
                d0 = m_dst(w0);
                if (d0[5] && m_reads(w1, d0[4:0])) begin
                    e_av = 1; e_aw = w0; e_tag = "R5";
                    m_split = 1; m_held = w1; m_ldv = 0;
                end else begin
                    e_av = (c0 == 1); e_aw = e_av ? w0 : 0;
                    e_mv = (c1 == 2 || c1 == 3); e_mw = e_mv ? w1 : 0;
                    e_tag = "R3";
                    m_ldv = (c1 == 2) && (w1[20:16] != 0);
                    m_ldr = w1[20:16];
                end
            end
        end
    endtask

    task automatic step(input logic v, input logic [63:0] d, input string note);
        string tag;
        @(negedge clk);
        pkt_valid = v;
        pkt_data  = d;
        #1;
        model_eval(v, d);
        tag = (note != "") ? note : e_tag;
        checks++;
        if ({pkt_ready, alu_issue_valid, alu_issue_word, mem_issue_valid, mem_issue_word, illegal_pkt}
            !== {e_ready, e_av, e_aw, e_mv, e_mw, e_ill}) begin
            failures++;
            $display("FAIL %s (words R11): got rdy=%b av=%b aw=%h mv=%b mw=%h ill=%b expected rdy=%b av=%b aw=%h mv=%b mw=%h ill=%b",
                     tag, pkt_ready, alu_issue_valid, alu_issue_word, mem_issue_valid, mem_issue_word,
                     illegal_pkt, e_ready, e_av, e_aw, e_mv, e_mw, e_ill);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; pkt_valid = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_split = 0; m_held = 0; m_ldv = 0; m_ldr = 0;
    endtask

    function automatic logic [31:0] gen_word(input int slot);
        int r = $urandom % 16;
        int a = $urandom % 4, b = $urandom % 4, c = $urandom % 4;
        if (slot == 0) begin
            if (r < 3) return 0;
            if (r < 8) return w_r(a, b, c);
            if (r < 10) return w_addi(a, b);
            if (r < 12) return w_br(a, b);
            if (r == 12) return w_lw(a, b);
            if (r == 13) return w_sw(a, b);
            if (r == 14) return {6'h0F, 5'(a), 5'(b), 16'h1234};
            return w_r(a, b, c);
        end
        if (r < 4) return 0;
        if (r < 9) return w_lw(a, b);
        if (r < 14) return w_sw(a, b);
        if (r == 14) return w_r(a, b, c);
        return {6'h3F, 5'(a), 5'(b), 16'h0001};
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] cur;
        logic        cv;
        void'($urandom(32'h5EED_2024));
        do_reset();
        step(0, 0, "R1 R10");
        // load r1, then reset: tracking must be gone (R1)
        step(1, {w_lw(1, 2), 32'h0}, "");
        do_reset();
        step(1, {32'h0, w_r(3, 1, 1)}, "R1");
        // split, then reset during the held cycle (R1)
        step(1, {w_lw(5, 4), w_addi(4, 0)}, "R5");
        do_reset();
        step(0, 0, "R1");
        // independent pair, R2 slot order
        step(1, {w_sw(4, 5), w_r(3, 1, 2)}, "R2 R3");
        step(1, {w_lw(9, 2), 32'h0}, "R3");
        step(1, {32'h0, w_r(10, 9, 1)}, "R6");
        step(1, {32'h0, w_r(10, 9, 1)}, "R6");
        step(1, {w_lw(9, 2), 32'h0}, "R3");
        step(1, {w_sw(9, 3), 32'h0}, "R6");
        step(1, {w_sw(9, 3), 32'h0}, "R6");
        // split via base and via store data
        step(1, {w_lw(7, 6), w_addi(6, 0)}, "R5");
        step(0, 0, "R5");
        step(1, {w_sw(8, 2), w_r(8, 1, 1)}, "R5");
        step(0, 0, "R5");
        // register 0
        step(1, {w_lw(2, 0), w_addi(0, 1)}, "R7");
        step(1, {w_lw(0, 3), 32'h0}, "R7");
        step(1, {w_sw(0, 0), w_r(0, 0, 0)}, "R7");
        // non-load forwarding
        step(1, {32'h0, w_r(11, 1, 2)}, "R8");
        step(1, {w_sw(11, 11), w_br(11, 11)}, "R8");
        // held load tracked
        step(1, {w_lw(12, 6), w_addi(6, 1)}, "R9");
        step(1, {32'h0, w_r(13, 12, 0)}, "R9");
        step(1, {32'h0, w_r(13, 12, 0)}, "R9");
        step(1, {32'h0, w_r(13, 12, 0)}, "R9");
        // illegal packets
        step(1, {32'h0, w_lw(1, 2)}, "R4");
        step(1, {w_r(1, 2, 3), 32'h0}, "R4");
        step(1, {32'h0, 32'h3C00_0001}, "R2 R4");
        // idle clears load tracking
        step(1, {w_lw(14, 2), 32'h0}, "R10");
        step(0, 0, "R10");
        step(1, {32'h0, w_r(15, 14, 14)}, "R10");
        // random traffic
        cur = {gen_word(1), gen_word(0)};
        cv = 1;
        for (int i = 0; i < 4000; i++) begin
            step(cv, cur, "");
            if (!cv || e_ready) begin
                cv  = ($urandom % 8) != 0;
                cur = {gen_word(1), gen_word(0)};
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule